// File: doc/BRIEF.md
# Asynchronous-Assert, Clocked-Release Reset Conditioner

This block takes a single asynchronous, reset-like input and produces an active-high output for one destination clock domain. The output rises at once when the input becomes active. No destination clock edge is needed for this. The output falls only after the inactive state has walked through a chain of destination-domain flip-flops, so the falling edge is always aligned to the destination clock.

The block is meant to drive the reset of a clock domain. Assertion does not depend on the clock, so the domain is reset promptly even while its clock is stopped or gated. Release waits for clock edges, so every register in the domain leaves reset on the same edge.

A parameter sets the length of the chain. A longer chain makes a metastable failure less likely but delays release by more cycles. A second parameter selects which input level counts as active: a high level (rising edge asserts) or a low level (falling edge asserts). The output stays active-high in both cases.

Top module: `arst_release_sync`

## Requirements
- R1: When the input becomes active, the output is 1 immediately, with no destination clock edge in between.
- R2: While the input stays active, the output stays 1 for any number of clock edges.
- R3: After the input goes inactive, the output is still 1 after clock edges 1 to STAGES-1 and is 0 from the STAGES-th rising edge on.
- R4: If the input becomes active again before release completes, the output stays 1. Counting then restarts, so a full STAGES edges of inactivity are needed again.
- R5: ASSERT_EDGE equal to EDGE_RISE (encoding 0) makes a high input active. EDGE_FALL (encoding 1) makes a low input active. The output is active-high for both settings.
- R6: STAGES sets the release latency for any value of 2 or more. A value below 2 is rejected when the design is elaborated.
- R7: Once released, the output stays 0 over any number of clock edges while the input stays inactive.
- R8: An active input pulse shorter than a clock period, arriving while the clock is stopped, still asserts the output. The output then holds until STAGES edges have passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination-domain clock; may be stopped |
| async_in | input | 1 | Asynchronous reset-like input; active level set by ASSERT_EDGE |
| sync_out | output | 1 | Active-high conditioned output, released on a clock edge |

## Verification
Three copies of the block are driven with one input pattern:
- a rising-edge copy and a falling-edge copy that fed the inverted input, both with three stages, which together separate the two polarity settings;
- a five-stage copy, which shows that release latency follows the stage count rather than a fixed value.

The table walk applies several patterns:
- long active spans, which show that assertion holds;
- release counted edge by edge, which pins down the exact release edge;
- a reassertion in the middle of release, which tells a restarted count from a resumed one.

A directed test drives a sub-cycle pulse with the clock stopped. This separates a truly asynchronous preset from one that only acts on a clock edge.

// File: rtl/arst_release_sync_pkg.sv
package arst_release_sync_pkg;

  // Which input transition starts assertion of the output.
  typedef enum logic {
    EDGE_RISE = 1'b0,   // high input level is active
    EDGE_FALL = 1'b1    // low input level is active
  } arst_edge_e;

  localparam int unsigned MIN_STAGES = 2;

endpackage

// File: rtl/arst_level_norm.sv
// Maps the raw input onto an active-high "assert now" level.
module arst_level_norm
  import arst_release_sync_pkg::*;
#(
  parameter arst_edge_e ASSERT_EDGE = EDGE_RISE
) (
  input  logic raw_in,
  output logic act_hi
);

  generate
    if (ASSERT_EDGE == EDGE_RISE) begin : g_rise
      assign act_hi = raw_in;
    end else begin : g_fall
      assign act_hi = ~raw_in;
    end
  endgenerate

endmodule

// File: rtl/arst_stage_chain.sv
// Flip-flop chain.
// - While act_hi is high, every stage is preset to 1 asynchronously.
// - Otherwise each clock edge shifts a 0 in at stage 0.
module arst_stage_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic act_hi,
  output logic tail
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge act_hi) begin
    if (act_hi) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b0};
    end
  end

  assign tail = chain_q[STAGES-1];

endmodule

// File: rtl/arst_release_sync.sv
module arst_release_sync
  import arst_release_sync_pkg::*;
#(
  parameter int unsigned STAGES      = 2,
  parameter arst_edge_e  ASSERT_EDGE = EDGE_RISE
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);

  // R6: a chain shorter than two stages is refused at elaboration.
  generate
    if (STAGES < MIN_STAGES) begin : g_bad_stages
      $error("arst_release_sync: STAGES must be at least 2");
    end
  endgenerate

  logic act_hi;

  arst_level_norm #(
    .ASSERT_EDGE(ASSERT_EDGE)
  ) u_norm (
    .raw_in (async_in),
    .act_hi (act_hi)
  );

  arst_stage_chain #(
    .STAGES(STAGES)
  ) u_chain (
    .clk    (clk),
    .act_hi (act_hi),
    .tail   (sync_out)
  );

endmodule

// File: rtl/arst_release_sync_chk.sv
module arst_release_sync_chk
  import arst_release_sync_pkg::*;
#(
  parameter int unsigned STAGES      = 2,
  parameter arst_edge_e  ASSERT_EDGE = EDGE_RISE
) (
  input logic clk,
  input logic async_in,
  input logic sync_out
);

  localparam int unsigned CW = $clog2(STAGES + 1);

  logic act;
  assign act = (ASSERT_EDGE == EDGE_RISE) ? async_in : ~async_in;

  // Checks stay disabled until the input has been active once.
  logic armed = 1'b0;
  always_ff @(posedge clk or posedge act) begin
    if (act) armed <= 1'b1;
  end

  // Counts clock edges of inactivity, saturating at STAGES.
  logic [CW-1:0] quiet_cnt = '0;
  always_ff @(posedge clk or posedge act) begin
    if (act) begin
      quiet_cnt <= '0;
    end else if (quiet_cnt < CW'(STAGES)) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R1 R2: an active input always shows as an asserted output.
  a_r1_active_asserts: assert property (@(negedge clk) disable iff (!armed)
    act |-> sync_out);

  // R2: the output is never low while the input is active.
  a_r2_no_low_when_active: assert property (@(posedge clk) disable iff (!armed)
    !sync_out |-> !act);

  // R3 R4: the output stays high until STAGES quiet edges have passed.
  a_r3_hold_before_count: assert property (@(posedge clk) disable iff (!armed)
    (quiet_cnt < CW'(STAGES)) |-> sync_out);

  // R3 R7: the output is low once STAGES quiet edges have passed.
  a_r7_low_after_count: assert property (@(posedge clk) disable iff (!armed)
    (quiet_cnt == CW'(STAGES) && !act) |-> !sync_out);

endmodule

bind arst_release_sync arst_release_sync_chk #(
  .STAGES      (STAGES),
  .ASSERT_EDGE (ASSERT_EDGE)
) u_chk (
  .clk      (clk),
  .async_in (async_in),
  .sync_out (sync_out)
);

// File: tb/test_arst_release_sync.sv
`timescale 1ns/1ps
module test_arst_release_sync;
  import arst_release_sync_pkg::*;

  logic clk  = 1'b0;
  logic stim = 1'b0;           // active-high stimulus level
  logic stim_n;
  logic out_pos, out_neg, out_deep;
  int n_cmp = 0;
  int n_bad = 0;

  assign stim_n = ~stim;

  arst_release_sync #(.STAGES(3), .ASSERT_EDGE(EDGE_RISE)) i_arst_release_sync (
    .clk(clk), .async_in(stim), .sync_out(out_pos));
  arst_release_sync #(.STAGES(3), .ASSERT_EDGE(EDGE_FALL)) i_arst_release_sync_neg (
    .clk(clk), .async_in(stim_n), .sync_out(out_neg));
  arst_release_sync #(.STAGES(5), .ASSERT_EDGE(EDGE_RISE)) i_arst_release_sync_deep (
    .clk(clk), .async_in(stim), .sync_out(out_deep));

  // One 250 MHz cycle: 2 ns high, 2 ns low. The clock is only run on demand.
  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      #2 clk = 1'b1;
      #2 clk = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Vector layout: [7] stimulus level, [6:3] clock edges, [0] expected output
  // for the three-stage copies.
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 4'd0, 2'b00, 1'b1},  // R1 immediate assert
    {1'b1, 4'd5, 2'b00, 1'b1},  // R2 hold while active
    {1'b0, 4'd2, 2'b00, 1'b1},  // R3 still high after 2 edges
    {1'b0, 4'd1, 2'b00, 1'b0},  // R3 released on 3rd edge
    {1'b0, 4'd4, 2'b00, 1'b0},  // R7 stays released
    {1'b1, 4'd0, 2'b00, 1'b1},  // R1 reassert without clock
    {1'b0, 4'd1, 2'b00, 1'b1},  // R4 partway into release
    {1'b1, 4'd0, 2'b00, 1'b1},  // R4 reassert mid-release
    {1'b0, 4'd2, 2'b00, 1'b1},  // R4 count restarted
    {1'b0, 4'd1, 2'b00, 1'b0}   // R4 release after full count
  };

  initial begin : watchdog
    #20000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    // Reset state: a clean activation sets every copy, no clock needed.
    #1 stim = 1'b1;
    #1;
    check("R1 reset pos", out_pos, 1'b1);
    check("R5 reset neg", out_neg, 1'b1);
    check("R1 reset deep", out_deep, 1'b1);

    // Table walk: both polarities (R5) must match the same expectation.
    for (int v = 0; v < NV; v++) begin
      stim = VEC[v][7];
      #1;
      tick(int'(VEC[v][6:3]));
      #1;
      check($sformatf("R3/R4 vec %0d pos", v), out_pos, VEC[v][0]);
      check($sformatf("R5 vec %0d neg", v), out_neg, VEC[v][0]);
    end

    // R6: the five-stage copy has seen 3 quiet edges so far; release on the 5th.
    check("R6 deep after 3", out_deep, 1'b1);
    tick(1);
    #1 check("R6 deep after 4", out_deep, 1'b1);
    tick(1);
    #1 check("R6 deep after 5", out_deep, 1'b0);

    // R8: sub-cycle pulse with the clock stopped.
    tick(2);
    #1 stim = 1'b1;
    #0.5 stim = 1'b0;
    #1;
    check("R8 pulse pos", out_pos, 1'b1);
    check("R8 pulse neg", out_neg, 1'b1);
    check("R8 pulse deep", out_deep, 1'b1);
    tick(2);
    #1 check("R8 hold pos", out_pos, 1'b1);
    tick(1);
    #1 check("R8 release pos", out_pos, 1'b0);
    check("R8 release neg", out_neg, 1'b0);
    check("R8 hold deep", out_deep, 1'b1);
    tick(2);
    #1 check("R8 release deep", out_deep, 1'b0);

    // R7: long quiet run keeps everything released.
    tick(20);
    #1 check("R7 long pos", out_pos, 1'b0);
    check("R7 long deep", out_deep, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule